// File: doc/BRIEF.md
# Opcode Length and Cycle Predecoder

This block watches the byte stream returned by the external program fetch path of an 8051-compatible core. For each byte that is an opcode it reads two small lookup tables. One gives the instruction length in bytes, and the other gives the count of machine cycles the instruction takes. Both tables share one 7-bit index. The index is built from the upper opcode nibble and a folded form of the lower nibble. All register-operand opcodes (low nibble 8 to F) share one entry per row, and the two indirect-operand opcodes (6 and 7) share another.

A byte counter follows the position inside the current instruction. From the counter and the table length the block tells the fetch logic two things: whether the byte now arriving is an opcode, and whether more operand bytes are still due. In the cycle after the last byte is accepted it pulses a completion strobe. Operand bytes are kept as the first and second parameter bytes, so the central controller never has to look at raw program bytes. When the instruction is a long or an absolute subroutine call, the block forms the call target address and presents it to the PC unit together with the completion strobe.

Top module: `opc_predecode`

## Requirements
- R1: After reset, is_opcode is 1, fetch_next is 0, instr_done is 0, call_valid is 0, and param1 and param2 are 0.
- R2: The lookup index is {fold(op[3:0]), op[7:4]}. fold maps 8..F to 7, maps 6 and 7 to 6, and leaves 0..5 unchanged. Opcodes that share an index (for example 0xB8 and 0xBF) report identical length and cycle values.
- R3: In the cycle after an opcode is accepted, instr_len holds the standard 8051 byte length of that opcode (1, 2 or 3). It keeps that value until the next opcode is accepted.
- R4: In the same cycle, instr_cyc holds the standard 8051 machine-cycle count (1, 2 or 4). For example, 0x84 and 0xA4 give 4, 0x00 gives 1, and 0x80 gives 2.
- R5: is_opcode is 1 exactly when the next accepted byte will be taken as an opcode. fetch_next is its complement: after an opcode of length N, fetch_next stays 1 until N-1 operand bytes have been accepted.
- R6: instr_done is a one-cycle pulse in the cycle after the final byte of an instruction is accepted. For a 1-byte opcode, the final byte is the opcode itself.
- R7: When an opcode is accepted, param1 and param2 are cleared to 0. After that, the first operand byte is loaded into param1 and the second into param2.
- R8: For opcode 0x12 (long call, 3 bytes), call_valid pulses together with instr_done, and call_target is {byte 2, byte 3}.
- R9: For any opcode whose bits [4:0] are 10001 (absolute call, 2 bytes), call_valid pulses together with instr_done. call_target is {A[15:11], op[7:5], byte 2}, where A is byte_addr of byte 2 plus 1.
- R10: A cycle with byte_valid at 0 changes no output except clearing instr_done and call_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | byte_in carries a program byte this cycle |
| byte_in | input | 8 | Program byte from the fetch path |
| byte_addr | input | 16 | Program address of byte_in |
| is_opcode | output | 1 | The next accepted byte is an opcode |
| fetch_next | output | 1 | More operand bytes are due for the current instruction |
| instr_done | output | 1 | Pulse: the current instruction has been fully fetched |
| instr_len | output | 2 | Byte length of the current instruction |
| instr_cyc | output | 3 | Machine-cycle count of the current instruction |
| param1 | output | 8 | First operand byte |
| param2 | output | 8 | Second operand byte |
| call_valid | output | 1 | Pulse: call_target holds a subroutine entry address |
| call_target | output | 16 | Subroutine entry address |

## Verification
The completion strobe of one instruction falls in the same cycle in which the next opcode is presented and accepted. With a run of 1-byte opcodes this happens on every cycle. The bench sends opcodes back to back, with no idle cycle, after calls and after single-byte instructions. In each of those cycles it checks that instr_done, call_valid and call_target still describe the finished instruction, while is_opcode and the next cycle's length and cycle values already describe the new one. Random idle gaps are mixed in so that the same overlap is also seen after stalls. An absolute call whose next-instruction address crosses a 2 KB page is also checked.

// File: rtl/opc_predecode.sv
`timescale 1ns/1ps
module opc_predecode (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_valid,
  input  logic [7:0]  byte_in,
  input  logic [15:0] byte_addr,
  output logic        is_opcode,
  output logic        fetch_next,
  output logic        instr_done,
  output logic [1:0]  instr_len,
  output logic [2:0]  instr_cyc,
  output logic [7:0]  param1,
  output logic [7:0]  param2,
  output logic        call_valid,
  output logic [15:0] call_target
);

  function automatic logic [1:0] len_tab(input logic [6:0] idx);
    logic [3:0] h;
    h = idx[3:0];
    case (idx[6:4])
      3'd0: len_tab = (h inside {4'h1, 4'h2, 4'h3, 4'h9}) ? 2'd3 :
                      (h inside {4'h0, 4'hE, 4'hF}) ? 2'd1 : 2'd2;
      3'd1: len_tab = 2'd2;
      3'd2: len_tab = (h inside {4'h0, 4'h1}) ? 2'd3 :
                      (h inside {4'h2, 4'h3, 4'hE, 4'hF}) ? 2'd1 : 2'd2;
      3'd3: len_tab = (h inside {4'h4, 4'h5, 4'h6}) ? 2'd3 : 2'd1;
      3'd4: len_tab = (h == 4'hB) ? 2'd3 :
                      (h inside {[4'h2:4'h7], 4'h9}) ? 2'd2 : 2'd1;
      3'd5: len_tab = (h inside {4'h7, 4'h8, 4'hB, 4'hD}) ? 2'd3 :
                      (h == 4'hA) ? 2'd1 : 2'd2;
      3'd6: len_tab = (h == 4'hB) ? 2'd3 :
                      (h inside {4'h7, 4'h8, 4'hA}) ? 2'd2 : 2'd1;
      default: len_tab = (h == 4'hB) ? 2'd3 :
                         (h inside {4'h7, 4'h8, 4'hA, 4'hD}) ? 2'd2 : 2'd1;
    endcase
  endfunction

  function automatic logic [2:0] cyc_tab(input logic [6:0] idx);
    logic [3:0] h;
    h = idx[3:0];
    case (idx[6:4])
      3'd0: cyc_tab = (h == 4'h0) ? 3'd1 : 3'd2;
      3'd1: cyc_tab = 3'd2;
      3'd2: cyc_tab = (h inside {[4'h4:4'h6], [4'hA:4'hD]}) ? 3'd1 : 3'd2;
      3'd3: cyc_tab = (h inside {[4'h0:4'h3], [4'hB:4'hD]}) ? 3'd1 : 3'd2;
      3'd4: cyc_tab = (h inside {4'h8, 4'hA}) ? 3'd4 : (h == 4'hB) ? 3'd2 : 3'd1;
      3'd5: cyc_tab = (h inside {4'h7, 4'h8, 4'hB, 4'hD}) ? 3'd2 : 3'd1;
      3'd6: cyc_tab = (h inside {4'h8, 4'hA, 4'hB}) ? 3'd2 : 3'd1;
      default: cyc_tab = (h inside {4'h8, 4'hA, 4'hB, 4'hD}) ? 3'd2 : 3'd1;
    endcase
  endfunction

  logic [1:0]  cnt;
  logic [7:0]  op_q;
  logic [2:0]  lo_fold;
  logic [6:0]  idx;
  logic [1:0]  len_lut;
  logic [2:0]  cyc_lut;
  logic [15:0] next_pc;
  logic        is_lcall, is_acall;

  assign lo_fold  = byte_in[3] ? 3'd7 : (byte_in[2:1] == 2'b11) ? 3'd6 : byte_in[2:0];
  assign idx      = {lo_fold, byte_in[7:4]};
  assign len_lut  = len_tab(idx);
  assign cyc_lut  = cyc_tab(idx);
  assign next_pc  = byte_addr + 16'd1;
  assign is_lcall = (op_q == 8'h12);
  assign is_acall = (op_q[4:0] == 5'b10001);

  assign is_opcode  = (cnt == 2'd0);
  assign fetch_next = (cnt != 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; op_q <= '0; instr_len <= '0; instr_cyc <= '0;
      param1 <= '0; param2 <= '0; instr_done <= 1'b0;
      call_valid <= 1'b0; call_target <= '0;
    end else begin
      instr_done <= 1'b0;
      call_valid <= 1'b0;
      if (byte_valid) begin
        if (cnt == 2'd0) begin
          op_q      <= byte_in;
          instr_len <= len_lut;
          instr_cyc <= cyc_lut;
          param1    <= '0;
          param2    <= '0;
          if (len_lut == 2'd1) instr_done <= 1'b1;
          else                 cnt <= 2'd1;
        end else begin
          if (cnt == 2'd1) param1 <= byte_in;
          else             param2 <= byte_in;
          if (cnt == instr_len - 2'd1) begin
            instr_done <= 1'b1;
            cnt        <= 2'd0;
            if (is_lcall) begin
              call_valid  <= 1'b1;
              call_target <= {param1, byte_in};
            end else if (is_acall) begin
              call_valid  <= 1'b1;
              call_target <= {next_pc[15:11], op_q[7:5], byte_in};
            end
          end else begin
            cnt <= cnt + 2'd1;
          end
        end
      end
    end
  end

  assert_done_after_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |-> $past(byte_valid));
  assert_call_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid |-> instr_done);
  assert_fetch_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fetch_next) |-> instr_done);
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |=> ($stable(fetch_next) && $stable(param1) && $stable(param2) && !instr_done));
  assert_len_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |-> (instr_len != 2'd0 && instr_cyc != 3'd0));

endmodule

// File: tb/opc_predecode_tb.sv
`timescale 1ns/1ps
module opc_predecode_tb;
  logic clk = 1'b0, rst_n = 1'b0, byte_valid = 1'b0;
  logic [7:0] byte_in = '0;
  logic [15:0] byte_addr = '0;
  logic is_opcode, fetch_next, instr_done, call_valid;
  logic [1:0] instr_len;
  logic [2:0] instr_cyc;
  logic [7:0] param1, param2;
  logic [15:0] call_target;

  always #2.5 clk = ~clk;

  opc_predecode u_dut (.clk, .rst_n, .byte_valid, .byte_in, .byte_addr,
    .is_opcode, .fetch_next, .instr_done, .instr_len, .instr_cyc,
    .param1, .param2, .call_valid, .call_target);

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  int e_cnt = 0, e_len = 0, e_cyc = 0;
  logic [7:0] e_op = 0, e_p1 = 0, e_p2 = 0;
  bit e_done = 0, e_call = 0;
  logic [15:0] e_tgt = 0, addr = 0;

  function automatic int ref_len(input logic [7:0] op);
    logic [3:0] hi = op[7:4], lo = op[3:0];
    if (lo >= 4'h8) return (hi == 4'hB) ? 3 : (hi inside {4'h7, 4'h8, 4'hA, 4'hD}) ? 2 : 1;
    if (lo >= 4'h6) return (hi == 4'hB) ? 3 : (hi inside {4'h7, 4'h8, 4'hA}) ? 2 : 1;
    if (lo == 4'h1) return 2;
    if (op inside {8'h10, 8'h20, 8'h30, 8'h90, 8'h02, 8'h12, 8'h43, 8'h53, 8'h63,
                   8'hB4, 8'h75, 8'h85, 8'hB5, 8'hD5}) return 3;
    if (op inside {8'h00, 8'hE0, 8'hF0, 8'h22, 8'h32, 8'hE2, 8'hF2, 8'h04, 8'h14,
                   8'h84, 8'hA4, 8'hC4, 8'hD4, 8'hE4, 8'hF4, 8'hA5}) return 1;
    if (lo == 4'h3) return 1;
    return 2;
  endfunction

  function automatic int ref_cyc(input logic [7:0] op);
    logic [3:0] hi = op[7:4], lo = op[3:0];
    if (op == 8'h84 || op == 8'hA4) return 4;
    if (lo >= 4'h8) return (hi inside {4'h8, 4'hA, 4'hB, 4'hD}) ? 2 : 1;
    if (lo >= 4'h6) return (hi inside {4'h8, 4'hA, 4'hB}) ? 2 : 1;
    case (lo)
      4'h0: return (hi == 4'h0) ? 1 : 2;
      4'h1: return 2;
      4'h2: return (hi inside {4'h4, 4'h5, 4'h6, 4'hA, 4'hB, 4'hC, 4'hD}) ? 1 : 2;
      4'h3: return (hi inside {4'h0, 4'h1, 4'h2, 4'h3, 4'hB, 4'hC, 4'hD}) ? 1 : 2;
      4'h4: return (hi == 4'hB) ? 2 : 1;
      default: return (hi inside {4'h7, 4'h8, 4'hB, 4'hD}) ? 2 : 1;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R5 is_opcode", is_opcode, e_cnt == 0);
    chk("R5 fetch_next", fetch_next, e_cnt != 0);
    chk("R6 instr_done", instr_done, e_done);
    chk("R3 instr_len", instr_len, e_len);
    chk("R4 instr_cyc", instr_cyc, e_cyc);
    chk("R7 param1", param1, e_p1);
    chk("R7 param2", param2, e_p2);
    chk(e_op == 8'h12 ? "R8 call_valid" : "R9 call_valid", call_valid, e_call);
    if (e_call) chk(e_op == 8'h12 ? "R8 call_target" : "R9 call_target", call_target, e_tgt);
  endtask

  task automatic step(input bit v, input logic [7:0] b);
    @(negedge clk);
    compare_all();
    byte_valid = v; byte_in = b; byte_addr = addr;
    e_done = 0; e_call = 0;
    if (v) begin
      if (e_cnt == 0) begin
        e_op = b; e_len = ref_len(b); e_cyc = ref_cyc(b); e_p1 = 0; e_p2 = 0;
        if (e_len == 1) e_done = 1; else e_cnt = 1;
      end else begin
        if (e_cnt == 1) e_p1 = b; else e_p2 = b;
        if (e_cnt == e_len - 1) begin
          e_done = 1; e_cnt = 0;
          if (e_op == 8'h12) begin e_call = 1; e_tgt = {e_p1, b}; end
          else if (e_op[4:0] == 5'b10001) begin
            e_call = 1; e_tgt = {addr[15:11] + 5'd0, e_op[7:5], b};
            e_tgt[15:11] = (addr + 16'd1) >> 11;
          end
        end else e_cnt++;
      end
      addr = addr + 16'd1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] ob;
    int len_b8, cyc_b8;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 is_opcode", is_opcode, 1); chk("R1 fetch_next", fetch_next, 0);
    chk("R1 instr_done", instr_done, 0); chk("R1 call_valid", call_valid, 0);
    chk("R1 param1", param1, 0); chk("R1 param2", param2, 0);

    // R8 long call, then back-to-back 1-byte opcodes (done overlaps next opcode)
    addr = 16'h0100;
    step(1, 8'h12); step(1, 8'hAB); step(1, 8'hCD);
    step(1, 8'h00); step(1, 8'h04); step(1, 8'hE8);
    // R9 absolute call whose next address crosses a 2 KB page
    addr = 16'h07FE;
    step(1, 8'hF1); step(1, 8'h5A);
    step(1, 8'h84); step(1, 8'hA4);
    // R10 stall inside an instruction
    step(1, 8'h75); step(0, 8'h99); step(0, 8'h33); step(1, 8'h11);
    step(0, 8'h12); step(1, 8'h22); step(0, 8'hFF);
    // R2 shared index: 0xB8 and 0xBF give same length/cycles
    step(1, 8'hB8); step(1, 8'h01); step(1, 8'h02); step(0, 8'h00);
    @(negedge clk); len_b8 = instr_len; cyc_b8 = instr_cyc;
    step(1, 8'hBF); step(1, 8'h03); step(1, 8'h04); step(0, 8'h00);
    @(negedge clk);
    chk("R2 shared len", instr_len, len_b8); chk("R2 shared cyc", instr_cyc, cyc_b8);

    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 16;
      ob = $urandom;
      if (e_cnt == 0 && r < 2) ob = 8'h12;
      else if (e_cnt == 0 && r < 4) ob = {ob[7:5], 5'b10001};
      if ($urandom % 64 == 0) addr = $urandom;
      step(($urandom % 4) != 0, ob);
    end
    step(0, 8'h00); step(0, 8'h00);

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule